// File: doc/BRIEF.md
# Fetch Queue with Branch Folding

This block sits between the instruction cache and the dispatch stage. Each clock it is offered a pair of fetched instructions, each with a valid bit and a flag that marks it as a branch. Branches never enter the queue. The first branch in the accepted part of the pair is sent out on a separate fold port toward the branch unit, so a taken branch costs no dispatch slot. The non-branch instructions are written into a six-entry ring in program order.

The dispatch side names how many instructions, zero to three, it takes this cycle. It always receives the oldest entries, and it never gets more than the ring holds. The three oldest entries are always on the head ports, each with its own valid bit. A `slot_taken` mask tells the fetcher which fetch slots were consumed, so that a held-back slot can be offered again. When the queue has fewer than two free entries, `fetch_stall` rises and the fetch pair is refused. A flush, raised when the branch unit finds a misprediction, empties the ring and discards the pair offered in the same cycle.

Top module: `fetch_fold_queue`

## Requirements
- R1: While `rst` is high and after it falls, `occupancy` is 0, `head_valid` is all zero, `fold_valid` is 0 and `fetch_stall` is 0.
- R2: Non-branch instructions enter the ring in program order. Slot 0 (the low `IW` bits of `fetch_instr`) comes before slot 1, and the oldest entry appears on `head_instr` bits `[IW-1:0]` one cycle after it is accepted.
- R3: An accepted instruction whose `fetch_branch` bit is 1 is not queued. In the next cycle `fold_valid` is 1 and `fold_instr` carries that instruction, and the other accepted slot still enqueues if it is not a branch.
- R4: When both slots are valid branches, only slot 0 is folded and slot 1 is not consumed (`slot_taken` = 2'b01).
- R5: The ring removes min(`disp_req`, `occupancy`) entries per cycle, oldest first, with at most three. `head_valid[i]` is 1 exactly when the ring holds more than i entries.
- R6: `fetch_stall` is 1 when `occupancy` is greater than DEPTH-2. While it is 1 the fetch pair is ignored: `slot_taken` = 0, no fold follows, and nothing is enqueued.
- R7: A cycle with `flush` high makes `occupancy` 0 and `fold_valid` 0 in the next cycle. It consumes no fetch slot (`slot_taken` = 0) and ignores `disp_req`.
- R8: Slot 1 is taken only when slot 0 is valid in the same cycle. A lone slot 1 is ignored.
- R9: The ring fills to exactly DEPTH (6) entries without loss, and `occupancy` never exceeds DEPTH.
- R10: With a push and a pop in the same cycle, `occupancy` becomes the old value minus the pop count plus the number of non-branch instructions accepted.
- R11: `slot_taken[i]` is 1 exactly when fetch slot i was consumed this cycle, whether it was queued or folded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 2 | Valid per fetch slot; bit 0 is the older slot |
| fetch_branch | input | 2 | Branch flag per fetch slot |
| fetch_instr | input | 2*IW | Slot 0 in bits [IW-1:0], slot 1 above |
| disp_req | input | $clog2(DISP_W+1) | Number of instructions the dispatcher takes this cycle |
| flush | input | 1 | Misprediction flush |
| slot_taken | output | 2 | Fetch slots consumed this cycle |
| fetch_stall | output | 1 | Fewer than two free entries; fetch pair refused |
| head_valid | output | DISP_W | Valid bit per head entry, entry 0 oldest |
| head_instr | output | DISP_W*IW | Oldest entries; entry i in bits [i*IW +: IW] |
| occupancy | output | $clog2(DEPTH+1) | Entries held |
| fold_valid | output | 1 | A branch was folded in the previous cycle |
| fold_instr | output | IW | The folded branch |

## Verification
The bench targets the pair compositions that a folding front end handles most easily by mistake. A branch in slot 0 must leave slot 1 queued, and a design that shifts badly would put the wrong word at the head. A double branch must fold only the first, and a design that folds both would report `slot_taken` = 11 and lose a branch. A lone slot 1 must be refused, and a design that accepts it would grow the occupancy. The bench also fills the ring to six entries and then dispatches three while fetch is stalled, checks that a flush discards a fetch pair carrying a branch, and asks for more entries than the ring holds. An off-by-one stall threshold would overflow the ring or refuse fetch at four, and a design that does not clamp the pop count would wrap its occupancy.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int unsigned FQ_FETCH_W = 2;

  // Advance a ring index by inc positions modulo depth (inc < depth).
  function automatic int unsigned fq_wrap(input int unsigned p,
                                          input int unsigned inc,
                                          input int unsigned depth);
    int unsigned s;
    s = p + inc;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/fq_fold_sort.sv
module fq_fold_sort #(
  parameter int IW = 32
) (
  input  logic            en,
  input  logic [1:0]      valid,
  input  logic [1:0]      branch,
  input  logic [2*IW-1:0] instr,
  output logic [1:0]      take,
  output logic [1:0]      push_cnt,
  output logic [IW-1:0]   push_a,
  output logic [IW-1:0]   push_b,
  output logic            fold_v,
  output logic [IW-1:0]   fold_instr
);
  logic [IW-1:0] i0, i1;
  logic          t0, t1, n0, n1;

  assign i0 = instr[IW-1:0];
  assign i1 = instr[2*IW-1:IW];

  always_comb begin
    t0 = en & valid[0];
    // slot 1 needs slot 0 in the same cycle and is held back behind a second branch
    t1 = en & valid[0] & valid[1] & ~(branch[0] & branch[1]);
    n0 = t0 & ~branch[0];
    n1 = t1 & ~branch[1];
    take       = {t1, t0};
    push_cnt   = {1'b0, n0} + {1'b0, n1};
    push_a     = n0 ? i0 : i1;
    push_b     = i1;
    fold_v     = (t0 & branch[0]) | (t1 & branch[1]);
    fold_instr = (t0 & branch[0]) ? i0 : i1;
  end
endmodule

// File: rtl/fq_ring.sv
module fq_ring
  import fq_pkg::*;
#(
  parameter int IW     = 32,
  parameter int DEPTH  = 6,
  parameter int DISP_W = 3,
  parameter int CW     = $clog2(DEPTH + 1),
  parameter int PRW    = $clog2(DISP_W + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic [1:0]           push_cnt,
  input  logic [IW-1:0]        push_a,
  input  logic [IW-1:0]        push_b,
  input  logic [PRW-1:0]       pop_req,
  output logic [CW-1:0]        occupancy,
  output logic [DISP_W-1:0]    head_valid,
  output logic [DISP_W*IW-1:0] head_instr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count, pop_n;
  logic [PW-1:0] wr_next1;

  assign wr_next1 = PW'(fq_wrap(32'(wr_ptr), 1, DEPTH));

  always_comb begin
    if (flush)                     pop_n = '0;
    else if (CW'(pop_req) > count) pop_n = count;
    else                           pop_n = CW'(pop_req);
  end

  // storage: plain writes, no reset, so the array maps to memory cells
  always_ff @(posedge clk) begin
    if (push_cnt != 2'd0) mem[wr_ptr]   <= push_a;
    if (push_cnt == 2'd2) mem[wr_next1] <= push_b;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      rd_ptr <= PW'(fq_wrap(32'(rd_ptr), 32'(pop_n), DEPTH));
      wr_ptr <= PW'(fq_wrap(32'(wr_ptr), 32'(push_cnt), DEPTH));
      count  <= count - pop_n + CW'(push_cnt);
    end
  end

  assign occupancy = count;

  for (genvar g = 0; g < DISP_W; g++) begin : g_head
    logic [PW-1:0] idx;
    assign idx = PW'(fq_wrap(32'(rd_ptr), g, DEPTH));
    assign head_instr[g*IW +: IW] = mem[idx];
    assign head_valid[g]          = (count > CW'(g));
  end
endmodule

// File: rtl/fetch_fold_queue.sv
module fetch_fold_queue
  import fq_pkg::*;
#(
  parameter int IW     = 32,
  parameter int DEPTH  = 6,
  parameter int DISP_W = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [1:0]                   fetch_valid,
  input  logic [1:0]                   fetch_branch,
  input  logic [2*IW-1:0]              fetch_instr,
  input  logic [$clog2(DISP_W+1)-1:0]  disp_req,
  input  logic                         flush,
  output logic [1:0]                   slot_taken,
  output logic                         fetch_stall,
  output logic [DISP_W-1:0]            head_valid,
  output logic [DISP_W*IW-1:0]         head_instr,
  output logic [$clog2(DEPTH+1)-1:0]   occupancy,
  output logic                         fold_valid,
  output logic [IW-1:0]                fold_instr
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int PRW = $clog2(DISP_W + 1);

  logic          accept_en, fold_v;
  logic [1:0]    push_cnt;
  logic [IW-1:0] push_a, push_b, fold_i;

  // stall whenever a full pair might not fit
  assign fetch_stall = (occupancy > CW'(DEPTH - int'(FQ_FETCH_W)));
  assign accept_en   = ~flush & ~fetch_stall;

  fq_fold_sort #(.IW(IW)) sort_i (
    .en(accept_en), .valid(fetch_valid), .branch(fetch_branch),
    .instr(fetch_instr), .take(slot_taken), .push_cnt(push_cnt),
    .push_a(push_a), .push_b(push_b), .fold_v(fold_v), .fold_instr(fold_i)
  );

  fq_ring #(.IW(IW), .DEPTH(DEPTH), .DISP_W(DISP_W), .CW(CW), .PRW(PRW)) ring_i (
    .clk(clk), .rst(rst), .flush(flush), .push_cnt(push_cnt),
    .push_a(push_a), .push_b(push_b), .pop_req(disp_req),
    .occupancy(occupancy), .head_valid(head_valid), .head_instr(head_instr)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) fold_valid <= 1'b0;
    else              fold_valid <= fold_v;
  end

  always_ff @(posedge clk) begin
    if (fold_v) fold_instr <= fold_i;
  end
endmodule

// File: rtl/fetch_fold_queue_chk.sv
module fetch_fold_queue_chk #(
  parameter int IW     = 32,
  parameter int DEPTH  = 6,
  parameter int DISP_W = 3
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        flush,
  input logic [1:0]                  fetch_valid,
  input logic [1:0]                  fetch_branch,
  input logic [$clog2(DISP_W+1)-1:0] disp_req,
  input logic [1:0]                  slot_taken,
  input logic                        fetch_stall,
  input logic [$clog2(DEPTH+1)-1:0]  occupancy,
  input logic                        fold_valid
);
  int exp_pop, exp_push;

  always_comb begin
    exp_pop  = (int'(disp_req) > int'(occupancy)) ? int'(occupancy) : int'(disp_req);
    exp_push = int'(slot_taken[0] & ~fetch_branch[0]) + int'(slot_taken[1] & ~fetch_branch[1]);
  end

  // R1: the cycle after reset the queue is empty
  a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (occupancy == '0 && !fold_valid));

  // R9: occupancy bounded by depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= DEPTH);

  // R6: a stalled cycle consumes no fetch slot
  a_r6_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    fetch_stall |-> slot_taken == 2'b00);

  // R7: flush empties the queue and cancels folding
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (occupancy == '0 && !fold_valid));

  // R4: double branch pair folds only the first
  a_r4_first_branch_only: assert property (@(posedge clk) disable iff (rst)
    (!flush && !fetch_stall && fetch_valid == 2'b11 && fetch_branch == 2'b11)
      |-> slot_taken == 2'b01);

  // R8: a lone slot 1 is never taken
  a_r8_slot1_alone: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid[0] |-> slot_taken == 2'b00);

  // R3: a consumed branch shows on the fold port next cycle
  a_r3_fold_next: assert property (@(posedge clk) disable iff (rst)
    (|(slot_taken & fetch_branch)) |=> fold_valid);

  // R10: occupancy update from pushes and clamped pops
  a_r10_occ_update: assert property (@(posedge clk) disable iff (rst)
    !flush |=> int'(occupancy) == int'($past(occupancy)) - $past(exp_pop) + $past(exp_push));
endmodule

bind fetch_fold_queue fetch_fold_queue_chk #(.IW(IW), .DEPTH(DEPTH), .DISP_W(DISP_W)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .fetch_valid(fetch_valid),
  .fetch_branch(fetch_branch), .disp_req(disp_req), .slot_taken(slot_taken),
  .fetch_stall(fetch_stall), .occupancy(occupancy), .fold_valid(fold_valid)
);

// File: tb/fetch_fold_queue_tb_top.sv
`timescale 1ns/1ps
module fetch_fold_queue_tb_top;
  localparam int IW = 32, DEPTH = 6, DISP_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       fetch_valid = '0, fetch_branch = '0;
  logic [2*IW-1:0]  fetch_instr = '0;
  logic [1:0]       disp_req = '0;
  logic             flush = 1'b0;
  logic [1:0]       slot_taken;
  logic             fetch_stall;
  logic [DISP_W-1:0] head_valid;
  logic [DISP_W*IW-1:0] head_instr;
  logic [2:0]       occupancy;
  logic             fold_valid;
  logic [IW-1:0]    fold_instr;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  fetch_fold_queue #(.IW(IW), .DEPTH(DEPTH), .DISP_W(DISP_W)) dut_i (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_branch(fetch_branch),
    .fetch_instr(fetch_instr), .disp_req(disp_req), .flush(flush),
    .slot_taken(slot_taken), .fetch_stall(fetch_stall), .head_valid(head_valid),
    .head_instr(head_instr), .occupancy(occupancy), .fold_valid(fold_valid),
    .fold_instr(fold_instr)
  );

  typedef struct packed {
    logic       fl;
    logic [1:0] dr;
    logic [1:0] v;
    logic [1:0] b;
    logic [7:0] t0;
    logic [7:0] t1;
    logic [1:0] etk;
    logic [2:0] eocc;
    logic       efv;
    logic [7:0] eft;
    logic [7:0] eht;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 2'd0, 2'b11, 2'b00, 8'hA1, 8'hA2, 2'b11, 3'd2, 1'b0, 8'h00, 8'hA1}, // R2 plain pair
    '{1'b0, 2'd0, 2'b11, 2'b01, 8'hB1, 8'hA3, 2'b11, 3'd3, 1'b1, 8'hB1, 8'hA1}, // R3 slot0 branch
    '{1'b0, 2'd0, 2'b11, 2'b10, 8'hA4, 8'hB2, 2'b11, 3'd4, 1'b1, 8'hB2, 8'hA1}, // R3 slot1 branch
    '{1'b0, 2'd0, 2'b11, 2'b11, 8'hB3, 8'hB4, 2'b01, 3'd4, 1'b1, 8'hB3, 8'hA1}, // R4 two branches
    '{1'b0, 2'd3, 2'b11, 2'b00, 8'hA5, 8'hA6, 2'b11, 3'd3, 1'b0, 8'h00, 8'hA4}, // R10 push+pop
    '{1'b0, 2'd0, 2'b11, 2'b00, 8'hA7, 8'hA8, 2'b11, 3'd5, 1'b0, 8'h00, 8'hA4}, // R2 to five
    '{1'b0, 2'd1, 2'b11, 2'b01, 8'hB5, 8'hA9, 2'b00, 3'd4, 1'b0, 8'h00, 8'hA5}, // R6 stalled
    '{1'b0, 2'd0, 2'b10, 2'b00, 8'hEE, 8'hA9, 2'b00, 3'd4, 1'b0, 8'h00, 8'hA5}, // R8 lone slot1
    '{1'b0, 2'd2, 2'b01, 2'b00, 8'hA9, 8'hEE, 2'b01, 3'd3, 1'b0, 8'h00, 8'hA7}, // R11 single slot
    '{1'b1, 2'd1, 2'b11, 2'b01, 8'hB6, 8'hAA, 2'b00, 3'd0, 1'b0, 8'h00, 8'h00}, // R7 flush
    '{1'b0, 2'd3, 2'b11, 2'b00, 8'hAB, 8'hAC, 2'b11, 3'd2, 1'b0, 8'h00, 8'hAB}, // R5 pop from empty
    '{1'b0, 2'd2, 2'b00, 2'b00, 8'hEE, 8'hEE, 2'b00, 3'd0, 1'b0, 8'h00, 8'h00}, // R5 drain
    '{1'b0, 2'd0, 2'b01, 2'b01, 8'hB7, 8'hEE, 2'b01, 3'd0, 1'b1, 8'hB7, 8'h00}  // R3 branch only
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tag(input logic [7:0] t);
    return {24'h0, t};
  endfunction

  task automatic drive(input logic fl, input logic [1:0] dr, input logic [1:0] v,
                       input logic [1:0] b, input logic [7:0] t0, input logic [7:0] t1);
    flush = fl; disp_req = dr; fetch_valid = v; fetch_branch = b;
    fetch_instr = {tag(t1), tag(t0)};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state during reset
    check("R1", "occupancy", 32'(occupancy), 0);
    check("R1", "head_valid", 32'(head_valid), 0);
    check("R1", "fold_valid", 32'(fold_valid), 0);
    check("R1", "fetch_stall", 32'(fetch_stall), 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(TBL[k].fl, TBL[k].dr, TBL[k].v, TBL[k].b, TBL[k].t0, TBL[k].t1);
      #1;
      check("R11", $sformatf("row %0d slot_taken", k), 32'(slot_taken), 32'(TBL[k].etk));
      @(posedge clk);
      #1;
      check("R10", $sformatf("row %0d occupancy", k), 32'(occupancy), 32'(TBL[k].eocc));
      check("R3", $sformatf("row %0d fold_valid", k), 32'(fold_valid), 32'(TBL[k].efv));
      if (TBL[k].efv)
        check("R3", $sformatf("row %0d fold_instr", k), fold_instr, tag(TBL[k].eft));
      if (TBL[k].eocc != 0)
        check("R2", $sformatf("row %0d head0", k), head_instr[IW-1:0], tag(TBL[k].eht));
      else
        check("R5", $sformatf("row %0d head_valid empty", k), 32'(head_valid), 0);
    end

    // R9: fill to six from empty
    @(negedge clk); drive(1'b0, 2'd0, 2'b11, 2'b00, 8'hC1, 8'hC2);
    @(negedge clk); drive(1'b0, 2'd0, 2'b11, 2'b00, 8'hC3, 8'hC4);
    @(negedge clk); drive(1'b0, 2'd0, 2'b11, 2'b00, 8'hC5, 8'hC6);
    @(negedge clk); drive(1'b0, 2'd0, 2'b00, 2'b00, 8'h00, 8'h00);
    #1;
    check("R9", "full occupancy", 32'(occupancy), 6);
    check("R6", "stall at full", 32'(fetch_stall), 1);
    check("R9", "head_valid full", 32'(head_valid), 3'b111);
    check("R9", "head0", head_instr[IW-1:0], tag(8'hC1));
    check("R9", "head1", head_instr[2*IW-1:IW], tag(8'hC2));
    check("R9", "head2", head_instr[3*IW-1:2*IW], tag(8'hC3));

    // R6: stalled fetch refused while three dispatch
    drive(1'b0, 2'd3, 2'b11, 2'b00, 8'hD1, 8'hD2);
    #1;
    check("R6", "stalled slot_taken", 32'(slot_taken), 0);
    @(posedge clk); #1;
    check("R5", "after pop3 occupancy", 32'(occupancy), 3);
    check("R5", "head0 after pop3", head_instr[IW-1:0], tag(8'hC4));
    check("R5", "head2 after pop3", head_instr[3*IW-1:2*IW], tag(8'hC6));

    // R10: pop three and push two together
    @(negedge clk); drive(1'b0, 2'd3, 2'b11, 2'b00, 8'hD1, 8'hD2);
    @(posedge clk); #1;
    check("R10", "pop3 push2 occupancy", 32'(occupancy), 2);
    check("R5", "head_valid partial", 32'(head_valid), 3'b011);
    check("R2", "head1 order", head_instr[2*IW-1:IW], tag(8'hD2));

    // R1: reset mid-run after a fold
    @(negedge clk); drive(1'b0, 2'd0, 2'b01, 2'b01, 8'hB8, 8'h00);
    @(negedge clk); drive(1'b0, 2'd0, 2'b00, 2'b00, 8'h00, 8'h00); rst = 1'b1;
    @(posedge clk); #1;
    check("R1", "reset occupancy", 32'(occupancy), 0);
    check("R1", "reset fold_valid", 32'(fold_valid), 0);
    check("R1", "reset head_valid", 32'(head_valid), 0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule